// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one general-purpose I/O port of `WIDTH` pins (16 by default). Software sets up the port through a small register bus. The port has four configuration registers: direction, attribute, data and a special-function mask. From these the block drives each pin's output enable, output level and pull-resistor controls.

The attribute bit means different things depending on direction:

- On an output pin it selects between inverted and straight drive of the data bit.
- On an input pin it selects between a floating pin and a pull whose polarity the data bit chooses.

A set mask bit gives the pin to a peripheral. The peripheral's output level and enable then reach the pad directly, and the GPIO settings no longer affect that pin.

Pin levels pass through a two-flop synchronizer. The synchronized levels are readable on the bus and are also forwarded to the peripherals. A change on any synchronized pin raises a one-cycle wakeup request, but only while the port's wakeup enable input is high.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every configuration register is 0, and all registers read 0. Every pin has its output enable low and its output level low, and every pin has its pull enabled with pull-down polarity (`pull_en` all 1, `pull_up` all 0).
- R2: A write with `reg_wr` high updates the register at `reg_addr` on the next rising clock edge. The register addresses are 0 data, 2 direction, 3 attribute and 4 mask, and each reads back what was written. Address 1 is read-only. Addresses 5 to 7 read 0 and ignore writes. Reads are combinational from `reg_addr`.
- R3: A pin with direction 1 (output), attribute 0 and mask 0 has its output enable high and drives the inverse of its data bit.
- R4: A pin with direction 1, attribute 1 and mask 0 has its output enable high and drives its data bit unchanged.
- R5: A pin with direction 0 (input), attribute 0 and mask 0 has its output enable low and its output level low. Its pull is enabled, with `pull_up` equal to the data bit (1 pull-up, 0 pull-down).
- R6: A pin with direction 0, attribute 1 and mask 0 floats: output enable low, output level low, `pull_en` 0 and `pull_up` 0.
- R7: A pin with mask 1 takes its output enable and level from `alt_oe` and `alt_out`, and has `pull_en` and `pull_up` at 0, whatever its direction, attribute and data bits.
- R8: Address 1 reads the synchronized pin level. A change on `pin_in` before a clock edge becomes visible there after the second following rising edge, and not after the first.
- R9: With `wake_en` high, a change of `pin_in` raises `wake_req` in the cycle after the second following rising edge, and only for that one cycle.
- R10: With `wake_en` low, `wake_req` stays low whatever the pins do.
- R11: `alt_in` carries the synchronized pin level for every pin, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for `reg_addr` |
| pin_in | input | WIDTH | Raw pad input levels |
| pin_oe | output | WIDTH | Pad output enables |
| pin_out | output | WIDTH | Pad output levels |
| pull_en | output | WIDTH | Pull resistor enable per pin |
| pull_up | output | WIDTH | Pull polarity, 1 up, 0 down |
| alt_out | input | WIDTH | Peripheral output levels |
| alt_oe | input | WIDTH | Peripheral output enables |
| alt_in | output | WIDTH | Synchronized pin levels to peripherals |
| wake_en | input | 1 | Wakeup enable for this port |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
A corrupted configuration register shows up at the pad outputs in the same cycle as the write that follows it, because the pad controls are combinational from the registers. The bench compares every pad output after each configuration vector, so such faults are caught without delay.

A synchronizer with the wrong depth moves the pin read and the wakeup pulse by a cycle. A stuck previous-value register makes the wakeup pulse too long or removes it. The bench samples these at exact cycles after a pin change, so both faults appear within three clock edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_DATA = 3'd0,
    RA_PIN  = 3'd1,
    RA_DIR  = 3'd2,
    RA_ATTR = 3'd3,
    RA_MASK = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pen;
    logic pup;
  } pad_ctl_t;

  // Per-pin pad control from configuration bits and peripheral inputs.
  function automatic pad_ctl_t pad_decode(input logic dir, input logic attr,
                                          input logic data, input logic mask,
                                          input logic sf_out, input logic sf_oe);
    pad_ctl_t c;
    c = '0;
    if (mask) begin
      c.oe  = sf_oe;
      c.out = sf_out;
    end else if (dir) begin
      c.oe  = 1'b1;
      c.out = attr ? data : ~data;
    end else begin
      c.pen = ~attr;
      c.pup = ~attr & data;
    end
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_level,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  attr_q,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  mask_q
);
  logic wr_data, wr_dir, wr_attr, wr_mask;

  assign wr_data = wr && (addr == RA_DATA);
  assign wr_dir  = wr && (addr == RA_DIR);
  assign wr_attr = wr && (addr == RA_ATTR);
  assign wr_mask = wr && (addr == RA_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      attr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      if (wr_attr) attr_q <= wdata;
      if (wr_mask) mask_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      RA_DATA: rdata = data_q;
      RA_PIN:  rdata = pin_level;
      RA_DIR:  rdata = dir_q;
      RA_ATTR: rdata = attr_q;
      RA_MASK: rdata = mask_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] attr_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] mask_q,
  input  logic [WIDTH-1:0] sf_out,
  input  logic [WIDTH-1:0] sf_oe,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pen,
  output logic [WIDTH-1:0] pad_pup
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pad_ctl_t ctl;
    assign ctl = pad_decode(dir_q[i], attr_q[i], data_q[i], mask_q[i],
                            sf_out[i], sf_oe[i]);
    assign pad_oe[i]  = ctl.oe;
    assign pad_out[i] = ctl.out;
    assign pad_pen[i] = ctl.pen;
    assign pad_pup[i] = ctl.pup;
  end
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic             enable,
  output logic [WIDTH-1:0] change,
  output logic             req
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;

  assign change = level ^ prev_q;
  assign req    = enable && (|change);
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pull_en,
  output logic [WIDTH-1:0]  pull_up,
  input  logic [WIDTH-1:0]  alt_out,
  input  logic [WIDTH-1:0]  alt_oe,
  output logic [WIDTH-1:0]  alt_in,
  input  logic              wake_en,
  output logic              wake_req
);
  logic [WIDTH-1:0] dir_q, attr_q, data_q, mask_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] pin_change;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_sync(pin_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pin_level(pin_sync), .rdata(reg_rdata),
    .dir_q(dir_q), .attr_q(attr_q), .data_q(data_q), .mask_q(mask_q)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_pads (
    .dir_q(dir_q), .attr_q(attr_q), .data_q(data_q), .mask_q(mask_q),
    .sf_out(alt_out), .sf_oe(alt_oe),
    .pad_oe(pin_oe), .pad_out(pin_out), .pad_pen(pull_en), .pad_pup(pull_up)
  );

  gpio_wake_det #(.WIDTH(WIDTH)) u_wake (
    .clk(clk), .rst_n(rst_n), .level(pin_sync), .enable(wake_en),
    .change(pin_change), .req(wake_req)
  );

  assign alt_in = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] attr_q,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pull_en,
  input logic [WIDTH-1:0] pull_up,
  input logic [WIDTH-1:0] alt_out,
  input logic [WIDTH-1:0] alt_oe,
  input logic [WIDTH-1:0] pin_sync,
  input logic             wake_en,
  input logic             wake_req
);
  // R3: inverted drive on outputs with attribute 0
  p_invert_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ ~data_q) & dir_q & ~attr_q & ~mask_q) == '0);

  // R4: straight drive on outputs with attribute 1
  p_plain_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_out ^ data_q) | ~pin_oe) & dir_q & attr_q & ~mask_q) == '0);

  // R5: data chooses pull polarity on pulled inputs
  p_pull_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pull_up ^ data_q) | ~pull_en | pin_oe) & ~dir_q & ~attr_q & ~mask_q) == '0);

  // R6: inputs with attribute 1 float
  p_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_en | pull_up | pin_oe) & ~dir_q & attr_q & ~mask_q) == '0);

  // R7: masked pins follow the peripheral
  p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_oe ^ alt_oe) | (pin_out ^ alt_out) | pull_en) & mask_q) == '0);

  // R9: any synchronized change with enable set raises the request
  p_wake_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && (pin_sync != $past(pin_sync))) |-> wake_req);

  // R9: no request without a synchronized change
  p_wake_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sync == $past(pin_sync)) |-> !wake_req);

  // R10: request gated by enable
  p_wake_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> wake_en);
endmodule

bind gpio_port_ctl gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .attr_q(attr_q), .data_q(data_q),
  .mask_q(mask_q), .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
  .pull_up(pull_up), .alt_out(alt_out), .alt_oe(alt_oe), .pin_sync(pin_sync),
  .wake_en(wake_en), .wake_req(wake_req)
);

// File: tb/test_gpio_port_ctl.sv
module test_gpio_port_ctl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_oe, pin_out, pull_en, pull_up;
  logic [W-1:0] alt_out = 16'h9669;
  logic [W-1:0] alt_oe = 16'h0FF0;
  logic [W-1:0] alt_in;
  logic         wake_en = 1'b0;
  logic         wake_req;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gpio_port_ctl i_gpio_port_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en), .pull_up(pull_up),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
    .wake_en(wake_en), .wake_req(wake_req)
  );

  // Vectors {dir, attr, data, mask} with the requirement each exercises.
  localparam logic [63:0] VECS [6] = '{
    {16'hFFFF, 16'h0000, 16'h00FF, 16'h0000},  // R3
    {16'hFFFF, 16'hFFFF, 16'h1234, 16'h0000},  // R4
    {16'h0000, 16'h0000, 16'hF0F0, 16'h0000},  // R5
    {16'h0000, 16'hFFFF, 16'h5555, 16'h0000},  // R6
    {16'hFF00, 16'h0F0F, 16'h3C3C, 16'h0000},  // R3 R4 R5 R6 mixed
    {16'hAAAA, 16'hCCCC, 16'hF00F, 16'h00FF}   // R7
  };
  localparam int VEC_TAG [6] = '{3, 4, 5, 6, 4, 7};

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] e_oe, e_out, e_pen, e_pup;
    logic [W-1:0] dv, av, xv, mv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", pin_oe, '0);
    check("R1 out", pin_out, '0);
    check("R1 pull_en", pull_en, '1);
    check("R1 pull_up", pull_up, '0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 read", v, '0);
    end

    // Vector table walk, R3..R7
    for (int k = 0; k < 6; k++) begin
      {dv, av, xv, mv} = VECS[k];
      wr(3'd2, dv); wr(3'd3, av); wr(3'd0, xv); wr(3'd4, mv);
      for (int b = 0; b < W; b++) begin
        if (mv[b]) begin
          e_oe[b] = alt_oe[b]; e_out[b] = alt_out[b]; e_pen[b] = 0; e_pup[b] = 0;
        end else if (dv[b]) begin
          e_oe[b] = 1; e_out[b] = (av[b] == xv[b]) ? 1'b1 : ~av[b] & ~xv[b];
          e_pen[b] = 0; e_pup[b] = 0;
        end else begin
          e_oe[b] = 0; e_out[b] = 0;
          e_pen[b] = (av[b] == 1'b0);
          e_pup[b] = (av[b] == 1'b0) && xv[b];
        end
      end
      n_run++;
      if ({pin_oe, pin_out, pull_en, pull_up} !== {e_oe, e_out, e_pen, e_pup}) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual %h/%h/%h/%h expected %h/%h/%h/%h",
                 VEC_TAG[k], k, pin_oe, pin_out, pull_en, pull_up,
                 e_oe, e_out, e_pen, e_pup);
      end
    end

    // R2 readback and ignored addresses
    wr(3'd0, 16'hA5C3); rd(3'd0, v); check("R2 data", v, 16'hA5C3);
    wr(3'd2, 16'h0F1E); rd(3'd2, v); check("R2 dir", v, 16'h0F1E);
    wr(3'd3, 16'h7788); rd(3'd3, v); check("R2 attr", v, 16'h7788);
    wr(3'd4, 16'h0000); rd(3'd4, v); check("R2 mask", v, 16'h0000);
    wr(3'd1, 16'hFFFF); rd(3'd0, v); check("R2 pin addr write", v, 16'hA5C3);
    rd(3'd1, v); check("R2 pin addr read", v, '0);
    wr(3'd6, 16'h1111); rd(3'd6, v); check("R2 unmapped", v, '0);
    rd(3'd2, v); check("R2 unmapped no side effect", v, 16'h0F1E);

    // R8 / R9 synchronizer latency and wake pulse
    @(negedge clk);
    wake_en = 1'b1; pin_in = 16'hBEEF; reg_addr = 3'd1;
    @(negedge clk);
    check("R8 after one edge", reg_rdata, '0);
    check("R9 no early wake", {15'd0, wake_req}, 16'd0);
    @(negedge clk);
    check("R8 after two edges", reg_rdata, 16'hBEEF);
    check("R9 wake pulse", {15'd0, wake_req}, 16'd1);
    @(negedge clk);
    check("R9 pulse one cycle", {15'd0, wake_req}, 16'd0);
    check("R11 alt_in", alt_in, 16'hBEEF);

    // R10 wake disabled
    wake_en = 1'b0; pin_in = 16'h0001;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R10 wake masked", {15'd0, wake_req}, 16'd0);
    end

    // R11 alt_in with all pins masked
    wr(3'd4, 16'hFFFF);
    check("R11 alt_in masked", alt_in, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule